// File: doc/BRIEF.md
# Serial Synthesizer Programming Sequencer

This block is the host-side engine that brings a frequency synthesizer out of power-up over a three-wire serial link: a serial clock, a data line and a latch strobe. It takes four 24-bit configuration words on parallel inputs. After a single start command it enables the synthesizer and writes the four words in a fixed order: the initialization word, the function word, the reference-divider word and the feedback-divider word. Each word goes out as three bytes, most significant byte first. The latch strobe is held low across all three bytes of a word. The strobe then rises to commit the word.

The serial clock is derived from the system clock by a parameterized divider. Data uses clock phase zero, so the receiver samples on the rising edge of the serial clock. Once the last word is committed, the block raises a one-cycle completion pulse. It then polls the synthesizer's lock-detect output until that output goes high or a timeout runs out. The outcome, locked or timed out, is held until the next start.

Top module: `synth_prog_seq`

## Requirements
- R1: After reset, `le` is 1, and `sclk`, `ce`, `busy`, `done`, `locked` and `timed_out` are all 0.
- R2: A `start` pulse while idle sets `ce`, `busy` to 1 and `le` to 0 at the next clock edge. It then writes `cfg_init`, `cfg_func`, `cfg_ref` and `cfg_fb`, in that order. Each word's input is read when that word's transfer begins.
- R3: Each word is sent as 24 rising `sclk` edges, all with `le` at 0. The bytes go out in the order bits [23:16], [15:8], [7:0], each byte most significant bit first. `le` rises after the 24th falling `sclk` edge.
- R4: `sdata` changes only while `sclk` is 0. Inside a word, `sclk` has a period of 2*CLK_DIV clock cycles, with CLK_DIV cycles low and CLK_DIV cycles high.
- R5: Between consecutive words, `le` stays 1 for at least 2*CLK_DIV cycles. `sclk` is 0 whenever `le` is 1.
- R6: `done` is a one-cycle pulse. It is asserted in the same cycle that `le` rises after the fourth word, and at no other time.
- R7: After the fourth word, `le` stays high for 2*CLK_DIV cycles. Polling then begins. If `lock_det` is 1 on the first poll cycle, `locked` goes to 1 and `busy` goes to 0 exactly 2*CLK_DIV+1 cycles after `done`.
- R8: If `lock_det` stays 0 throughout polling, `timed_out` goes to 1 and `busy` goes to 0 exactly 2*CLK_DIV+LOCK_WAIT cycles after `done`. `locked` and `timed_out` are never both 1.
- R9: `locked` and `timed_out` hold their value while idle, whatever `lock_det` does. A new start clears both. A `start` while `busy` is ignored and adds no frame.
- R10: `ce` stays 1 from the first start onward, including while busy and after the sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the programming sequence (used only while idle) |
| cfg_init | input | 24 | First word: initialization |
| cfg_func | input | 24 | Second word: function settings |
| cfg_ref | input | 24 | Third word: reference divider |
| cfg_fb | input | 24 | Fourth word: feedback divider |
| lock_det | input | 1 | Lock-detect level from the synthesizer |
| sclk | output | 1 | Serial clock, idles low |
| sdata | output | 1 | Serial data, most significant bit first |
| le | output | 1 | Latch strobe, low while a word is shifted |
| ce | output | 1 | Synthesizer enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the fourth word is committed |
| locked | output | 1 | Lock seen during polling (held) |
| timed_out | output | 1 | Polling expired without lock (held) |

## Verification
Every output is registered, so a `start` applied before a clock edge shows up on `ce`, `le` and `busy` at the sample taken half a cycle after that edge. The bench checks these at that point. Frame content, bit timing and inter-word gaps come from a receiver model. The model watches the serial pins at every falling system-clock edge and judges each word when `le` rises. The poll results are timed by counting falling edges from the sample where `done` is seen. The result is due exactly 2*CLK_DIV+1 samples later for an immediate lock, and 2*CLK_DIV+LOCK_WAIT samples later for a timeout.

// File: rtl/synth_prog_seq.sv
module synth_prog_seq #(
  parameter int CLK_DIV   = 4,
  parameter int LOCK_WAIT = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [23:0] cfg_init,
  input  logic [23:0] cfg_func,
  input  logic [23:0] cfg_ref,
  input  logic [23:0] cfg_fb,
  input  logic        lock_det,
  output logic        sclk,
  output logic        sdata,
  output logic        le,
  output logic        ce,
  output logic        busy,
  output logic        done,
  output logic        locked,
  output logic        timed_out
);
  localparam int DW = $clog2(CLK_DIV + 1);
  localparam int TW = $clog2(LOCK_WAIT + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP, S_POLL} st_t;

  st_t         state;
  logic [DW-1:0] div_cnt;
  logic [TW-1:0] tmo_cnt;
  logic [4:0]  bit_cnt;
  logic [1:0]  widx;
  logic        half;
  logic [23:0] shreg;
  logic [23:0] next_word;
  logic        tick;

  assign tick  = div_cnt == DW'(CLK_DIV - 1);
  assign sdata = shreg[23];
  assign busy  = state != S_IDLE;

  always_comb begin
    case (widx)
      2'd0:    next_word = cfg_func;
      2'd1:    next_word = cfg_ref;
      default: next_word = cfg_fb;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || state == S_IDLE || tick) div_cnt <= '0;
    else                                   div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sclk      <= 1'b0;
      le        <= 1'b1;
      ce        <= 1'b0;
      done      <= 1'b0;
      locked    <= 1'b0;
      timed_out <= 1'b0;
      widx      <= '0;
      bit_cnt   <= '0;
      half      <= 1'b0;
      shreg     <= '0;
      tmo_cnt   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          ce        <= 1'b1;
          le        <= 1'b0;
          locked    <= 1'b0;
          timed_out <= 1'b0;
          widx      <= '0;
          shreg     <= cfg_init;
          bit_cnt   <= '0;
          half      <= 1'b0;
          state     <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          if (!half) begin
            sclk <= 1'b1;
            half <= 1'b1;
          end else begin
            sclk <= 1'b0;
            half <= 1'b0;
            if (bit_cnt == 5'd23) begin
              le    <= 1'b1;
              state <= S_GAP;
              if (widx == 2'd3) done <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              shreg   <= {shreg[22:0], 1'b0};
            end
          end
        end
        S_GAP: if (tick) begin
          if (!half) half <= 1'b1;
          else begin
            half <= 1'b0;
            if (widx == 2'd3) begin
              tmo_cnt <= '0;
              state   <= S_POLL;
            end else begin
              widx    <= widx + 1'b1;
              shreg   <= next_word;
              bit_cnt <= '0;
              le      <= 1'b0;
              state   <= S_SHIFT;
            end
          end
        end
        default: begin
          if (lock_det) begin
            locked <= 1'b1;
            state  <= S_IDLE;
          end else if (tmo_cnt == TW'(LOCK_WAIT - 1)) begin
            timed_out <= 1'b1;
            state     <= S_IDLE;
          end else begin
            tmo_cnt <= tmo_cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/synth_prog_seq_chk.sv
module synth_prog_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic lock_det,
  input logic sclk,
  input logic sdata,
  input logic le,
  input logic ce,
  input logic busy,
  input logic done,
  input logic locked,
  input logic timed_out
);
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (le && !sclk)); // R1
  AST_START_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !le && ce)); // R2
  AST_DATA_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> !sclk); // R4
  AST_LE_RISE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(le) |-> !sclk); // R3
  AST_LE_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    le |-> !sclk); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_ON_LE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(le)); // R6
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked && timed_out)); // R8
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(locked) && $stable(timed_out))); // R9
  AST_CE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> ce); // R10
endmodule

bind synth_prog_seq synth_prog_seq_chk chk_i (.*);

// File: tb/synth_prog_seq_tb.sv
module synth_prog_seq_tb_top;
  localparam int DIV = 2;
  localparam int LW  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic lock_det = 1'b0;
  logic [23:0] cfg_init = '0, cfg_func = '0, cfg_ref = '0, cfg_fb = '0;
  logic sclk, sdata, le, ce, busy, done, locked, timed_out;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  synth_prog_seq #(.CLK_DIV(DIV), .LOCK_WAIT(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_init(cfg_init), .cfg_func(cfg_func), .cfg_ref(cfg_ref), .cfg_fb(cfg_fb),
    .lock_det(lock_det), .sclk(sclk), .sdata(sdata), .le(le), .ce(ce),
    .busy(busy), .done(done), .locked(locked), .timed_out(timed_out));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // receiver model of the serial link
  logic [23:0] exp_w [4];
  logic [23:0] rx;
  int nbits = 0, nframes = 0, gap = 0, since_rise = 0;
  bit le_bad = 0, data_bad = 0, per_bad = 0;
  logic p_sclk = 1'b0, p_sdata = 1'b0, p_le = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (sclk && !p_sclk) begin
        if (le) le_bad = 1;
        rx = {rx[22:0], sdata};
        nbits++;
        if (nbits > 1 && since_rise != 2 * DIV) per_bad = 1;
        since_rise = 1;
      end else since_rise++;
      if (sclk && p_sclk && sdata != p_sdata) data_bad = 1;
      if (!le && p_le) begin
        if (nframes > 0 && nframes < 4) chk(gap >= 2 * DIV, "R5 inter-word gap", gap, 2 * DIV);
        nbits = 0; rx = '0; le_bad = 0; data_bad = 0; per_bad = 0;
      end
      if (le) gap++; else gap = 0;
      if (le && !p_le) begin
        chk(nbits == 24, "R3 bits per word", nbits, 24);
        chk(!le_bad, "R3 le low on every rising sclk", le_bad, 0);
        chk(!data_bad, "R4 sdata stable while sclk high", data_bad, 0);
        chk(!per_bad, "R4 sclk period", per_bad, 0);
        if (nframes < 4) chk(rx == exp_w[nframes], "R2 word content/order", rx, exp_w[nframes]);
        else chk(0, "R9 extra frame", nframes + 1, 4);
        nframes++;
      end
      if (done) chk(le && !p_le && nframes == 4, "R6 done with fourth le rise", nframes, 4);
    end
    p_sclk = sclk; p_sdata = sdata; p_le = le;
  end

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(le == 1'b1, "R1 le", le, 1);
    chk({sclk, ce, busy, done, locked, timed_out} == 6'b0, "R1 outputs low",
        {sclk, ce, busy, done, locked, timed_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load(input logic [23:0] a, input logic [23:0] b,
                      input logic [23:0] c, input logic [23:0] d);
    cfg_init = a; cfg_func = b; cfg_ref = c; cfg_fb = d;
    exp_w[0] = a; exp_w[1] = b; exp_w[2] = c; exp_w[3] = d;
    nframes = 0;
  endtask

  task automatic kick();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(ce && busy && !le, "R2 start response", {ce, busy, le}, 3'b110);
    chk(!locked && !timed_out, "R9 status cleared on start", {locked, timed_out}, 0);
  endtask

  task automatic wait_end(output int lat);
    while (!done) @(negedge clk);
    lat = 0;
    while (busy) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_lock();
    int lat;
    load(24'hA5C3_0F, 24'h00_0001, 24'h80_0000, 24'hFF_FFFE);
    lock_det = 1'b1;
    kick();
    wait_end(lat);
    chk(lat == 2 * DIV + 1, "R7 lock latency", lat, 2 * DIV + 1);
    chk(locked && !timed_out, "R7 locked status", {locked, timed_out}, 2'b10);
    chk(nframes == 4, "R2 four words", nframes, 4);
    chk(ce, "R10 ce stays high", ce, 1);
  endtask

  task automatic t_hold();
    lock_det = 1'b0;
    repeat (20) @(negedge clk);
    chk(locked && !timed_out, "R9 status held idle", {locked, timed_out}, 2'b10);
    chk(ce && !busy, "R10 ce after sequence", {ce, busy}, 2'b10);
  endtask

  task automatic t_timeout();
    int lat;
    load(24'h123456, 24'h789ABC, 24'hDEF012, 24'h5A5A5A);
    lock_det = 1'b0;
    kick();
    wait_end(lat);
    chk(lat == 2 * DIV + LW, "R8 timeout latency", lat, 2 * DIV + LW);
    chk(timed_out && !locked, "R8 timeout status", {locked, timed_out}, 2'b01);
    lock_det = 1'b1;
    repeat (10) @(negedge clk);
    chk(timed_out && !locked, "R9 lock_det ignored idle", {locked, timed_out}, 2'b01);
  endtask

  task automatic t_restart_ignored();
    int lat;
    load(24'hF0F0F0, 24'h0F0F0F, 24'hC0FFEE, 24'h000000);
    lock_det = 1'b0;
    kick();
    repeat (60) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (150) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_end(lat);
    repeat (20) @(negedge clk);
    chk(nframes == 4, "R9 start while busy ignored", nframes, 4);
    chk(!busy && timed_out, "R9 single run ended", {busy, timed_out}, 2'b01);
  endtask

  initial begin
    t_reset();
    t_lock();
    t_hold();
    t_timeout();
    t_restart_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 50000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 50000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule